// File: doc/BRIEF.md
# Type-C Attach Toggle Detector

This block searches for a partner on the two configuration-channel pins of a Type-C port. Software writes a small control word that holds a role mode and a toggle enable. While toggling is enabled, the block controls the termination switches itself. It steps through probe phases of fixed length. In a source probe, a single pull-up sits on one pin. In a sink probe, both pins get pull-downs. Digital comparator flags tell the block which terminations the far end presents.

When a candidate outcome is seen on two consecutive samples within one phase, the block stops. It freezes the termination it had in place and publishes a 3-bit outcome code. It also raises a one-cycle done pulse and a sticky interrupt flag, which software clears with an acknowledge strobe. Software then clears the toggle enable, and its own manual pull-up and pull-down settings drive the pins directly. The outcome code stays visible until toggling is enabled again.

Top module: `cc_attach_toggler`

## Requirements
- R1: After synchronous reset, settle_code is 0, done_pulse and done_irq are 0, and with tog_ctrl at 0 the switch outputs equal the manual inputs.
- R2: tog_ctrl bit 0 is the toggle enable and bits 2:1 are the mode (3 source-only, 2 sink-only, 1 dual-role, 0 none). With bit 0 clear, sw_pu and sw_pd equal man_pu and man_pd. In all vectors, bit 0 is CC1 and bit 1 is CC2.
- R3: While the toggle enable is set, the manual inputs have no effect. In the first cycle after the enable rises, all four switches are off.
- R4: In source-only mode, exactly one pull-up is on and no pull-down is on. The pull-up starts on CC1 and moves to the other pin every PHASE_CYCLES cycles.
- R5: In sink-only mode, both pull-downs are on and no pull-up is on.
- R6: In dual-role mode, the phases repeat in the order: pull-up on CC1, pull-up on CC2, pull-downs on both. Each phase lasts PHASE_CYCLES cycles.
- R7: In mode 0 with toggling enabled, no switch is on and the block never settles.
- R8: The outcome codes are as follows. With the pull-up on CCx, Rd on that pin gives 1 for CC1 or 2 for CC2, and Ra on both pins gives 7. In a sink phase, Rp on CC1 gives 5 and takes priority over Rp on CC2, which gives 6. Rd on a pin without the pull-up is ignored.
- R9: The block settles only when the same nonzero candidate is seen in two consecutive cycles of one phase. A one-cycle detection leaves the code at 0.
- R10: After it settles, the block stops toggling. The termination of the settling phase and the code hold for as long as the enable stays set.
- R11: done_pulse is high for exactly the one cycle after the settling sample. done_irq rises with it and stays set until irq_ack is applied.
- R12: A rising toggle enable returns the code to 0 and restarts the search from the mode's first phase.
- R13: After the enable is cleared, the settled code stays readable until the next rising enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tog_ctrl | input | 3 | Bit 0 toggle enable, bits 2:1 mode |
| man_pu | input | 2 | Manual pull-up enables (bit 0 CC1) |
| man_pd | input | 2 | Manual pull-down enables (bit 0 CC1) |
| rd_seen | input | 2 | Comparator: Rd present per pin |
| ra_seen | input | 2 | Comparator: Ra present per pin |
| rp_seen | input | 2 | Comparator: Rp present per pin |
| irq_ack | input | 1 | Clears the sticky done interrupt |
| sw_pu | output | 2 | Pull-up switch enables |
| sw_pd | output | 2 | Pull-down switch enables |
| settle_code | output | 3 | Outcome code, 0 while running |
| done_pulse | output | 1 | One-cycle settle pulse |
| done_irq | output | 1 | Sticky done interrupt |

## Verification
The bench builds the block with PHASE_CYCLES set to 8. At that length, several full rotations of the dual-role phase sequence fit into a short run, and phase boundaries can be checked at exact cycles. The short phase also reaches the case where a detection on CC2 must wait for the pull-up to move before it counts. It also allows a candidate to be timed against the debounce clear at a phase edge.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_DUAL = 2'd1,
        MODE_SINK = 2'd2,
        MODE_SRC  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PU1  = 2'd1,
        PH_PU2  = 2'd2,
        PH_PD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [1:0] pu;
        logic [1:0] pd;
    } term_t;

    localparam logic [2:0] CODE_RUN   = 3'd0;
    localparam logic [2:0] CODE_SRC1  = 3'd1;
    localparam logic [2:0] CODE_SRC2  = 3'd2;
    localparam logic [2:0] CODE_SNK1  = 3'd5;
    localparam logic [2:0] CODE_SNK2  = 3'd6;
    localparam logic [2:0] CODE_AUDIO = 3'd7;

    function automatic phase_e first_phase(input mode_e m);
        case (m)
            MODE_NONE: return PH_IDLE;
            MODE_SINK: return PH_PD;
            default:   return PH_PU1;
        endcase
    endfunction

    function automatic phase_e next_phase(input phase_e p, input mode_e m);
        case (p)
            PH_PU1:  return PH_PU2;
            PH_PU2:  return (m == MODE_DUAL) ? PH_PD : PH_PU1;
            PH_PD:   return (m == MODE_SINK) ? PH_PD : PH_PU1;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic term_t phase_term(input phase_e p);
        term_t t;
        t = '0;
        case (p)
            PH_PU1:  t.pu = 2'b01;
            PH_PU2:  t.pu = 2'b10;
            PH_PD:   t.pd = 2'b11;
            default: t = '0;
        endcase
        return t;
    endfunction

    function automatic logic [2:0] detect(input phase_e p, input logic [1:0] rd,
                                          input logic [1:0] ra, input logic [1:0] rp);
        logic [2:0] c;
        c = CODE_RUN;
        case (p)
            PH_PU1: begin
                if (rd[0])            c = CODE_SRC1;
                else if (ra == 2'b11) c = CODE_AUDIO;
            end
            PH_PU2: begin
                if (rd[1])            c = CODE_SRC2;
                else if (ra == 2'b11) c = CODE_AUDIO;
            end
            PH_PD: begin
                if (rp[0])            c = CODE_SNK1;
                else if (rp[1])       c = CODE_SNK2;
            end
            default: c = CODE_RUN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cct_phase_timer.sv
module cct_phase_timer #(
    parameter int PHASE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    output logic wrap_o
);
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);

endmodule

// File: rtl/cct_debounce.sv
module cct_debounce (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       run_i,
    input  logic [2:0] cand_i,
    output logic       settle_o
);
    logic [2:0] prev_q;

    assign settle_o = run_i && (cand_i != 3'd0) && (cand_i == prev_q);

    always_ff @(posedge clk) begin
        if (rst || clear_i || !run_i) begin
            prev_q <= 3'd0;
        end else begin
            prev_q <= cand_i;
        end
    end

    // R9
    two_sample_chk: assert property (@(posedge clk) disable iff (rst)
        settle_o |-> (cand_i == $past(cand_i)));

endmodule

// File: rtl/cct_sw_mux.sv
module cct_sw_mux
    import cct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tog_en_i,
    input  logic       owned_i,
    input  phase_e     phase_i,
    input  logic [1:0] man_pu_i,
    input  logic [1:0] man_pd_i,
    output logic [1:0] pu_o,
    output logic [1:0] pd_o
);
    term_t auto_t;

    always_comb begin
        auto_t = phase_term(phase_i);
        if (owned_i) begin
            pu_o = auto_t.pu;
            pd_o = auto_t.pd;
        end else if (tog_en_i) begin
            pu_o = 2'b00;
            pd_o = 2'b00;
        end else begin
            pu_o = man_pu_i;
            pd_o = man_pd_i;
        end
    end

    // R4
    single_pullup_chk: assert property (@(posedge clk) disable iff (rst)
        tog_en_i |-> ($countones(pu_o) <= 1));

    // R3
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        tog_en_i |-> ((pu_o & pd_o) == 2'b00));

endmodule

// File: rtl/cc_attach_toggler.sv
module cc_attach_toggler
    import cct_pkg::*;
#(
    parameter int PHASE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] tog_ctrl,
    input  logic [1:0] man_pu,
    input  logic [1:0] man_pd,
    input  logic [1:0] rd_seen,
    input  logic [1:0] ra_seen,
    input  logic [1:0] rp_seen,
    input  logic       irq_ack,
    output logic [1:0] sw_pu,
    output logic [1:0] sw_pd,
    output logic [2:0] settle_code,
    output logic       done_pulse,
    output logic       done_irq
);
    logic       toggle_en;
    mode_e      mode;
    logic       tog_q;
    logic       settled_q;
    phase_e     phase_q;
    logic       start;
    logic       run;
    logic       wrap;
    logic       settle;
    logic [2:0] cand;

    assign toggle_en = tog_ctrl[0];
    assign mode      = mode_e'(tog_ctrl[2:1]);
    assign start     = toggle_en && !tog_q;
    assign run       = toggle_en && tog_q && !settled_q;
    assign cand      = detect(phase_q, rd_seen, ra_seen, rp_seen);

    cct_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .restart_i(start),
        .run_i    (run),
        .wrap_o   (wrap)
    );

    cct_debounce deb_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start || wrap),
        .run_i   (run),
        .cand_i  (cand),
        .settle_o(settle)
    );

    cct_sw_mux mux_i (
        .clk     (clk),
        .rst     (rst),
        .tog_en_i(toggle_en),
        .owned_i (toggle_en && tog_q),
        .phase_i (phase_q),
        .man_pu_i(man_pu),
        .man_pd_i(man_pd),
        .pu_o    (sw_pu),
        .pd_o    (sw_pd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q       <= 1'b0;
            settled_q   <= 1'b0;
            phase_q     <= PH_IDLE;
            settle_code <= CODE_RUN;
            done_pulse  <= 1'b0;
            done_irq    <= 1'b0;
        end else begin
            tog_q      <= toggle_en;
            done_pulse <= 1'b0;
            if (start) begin
                phase_q     <= first_phase(mode);
                settled_q   <= 1'b0;
                settle_code <= CODE_RUN;
            end else if (settle) begin
                settled_q   <= 1'b1;
                settle_code <= cand;
                done_pulse  <= 1'b1;
            end else if (wrap) begin
                phase_q <= next_phase(phase_q, mode);
            end
            if (settle) begin
                done_irq <= 1'b1;
            end else if (irq_ack) begin
                done_irq <= 1'b0;
            end
        end
    end

    // R12
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (settle_code == CODE_RUN));

    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !irq_ack) |=> done_irq);

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((settle_code != CODE_RUN) && !start) |=> $stable(settle_code));

    // R7
    none_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (toggle_en && tog_q && phase_q == PH_IDLE) |-> (sw_pu == 2'b00 && sw_pd == 2'b00));

endmodule

// File: tb/cc_attach_toggler_tb.sv
module cc_attach_toggler_tb_top;

    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] tog_ctrl;
    logic [1:0] man_pu, man_pd, rd_seen, ra_seen, rp_seen;
    logic       irq_ack;
    logic [1:0] sw_pu, sw_pd;
    logic [2:0] settle_code;
    logic       done_pulse, done_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cc_attach_toggler #(.PHASE_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst), .tog_ctrl(tog_ctrl),
        .man_pu(man_pu), .man_pd(man_pd),
        .rd_seen(rd_seen), .ra_seen(ra_seen), .rp_seen(rp_seen),
        .irq_ack(irq_ack), .sw_pu(sw_pu), .sw_pd(sw_pd),
        .settle_code(settle_code), .done_pulse(done_pulse), .done_irq(done_irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_tog(input logic [1:0] m);
        tog_ctrl = {m, 1'b1};
        tick(1);
    endtask

    task automatic stop_tog();
        tog_ctrl[0] = 1'b0;
        tick(1);
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pu", {6'd0, sw_pu}, 8'h00);
        chk("R1 pd", {6'd0, sw_pd}, 8'h00);
        chk("R1 code", {5'd0, settle_code}, 8'h00);
        chk("R1 irq", {6'd0, done_pulse, done_irq}, 8'h00);
    endtask

    task automatic t_manual();
        man_pu = 2'b10; man_pd = 2'b01; tick(1);
        chk("R2 pu", {6'd0, sw_pu}, 8'h02);
        chk("R2 pd", {6'd0, sw_pd}, 8'h01);
        man_pu = 2'b01; man_pd = 2'b10; tick(1);
        chk("R2 pu2", {6'd0, sw_pu}, 8'h01);
        chk("R2 pd2", {6'd0, sw_pd}, 8'h02);
    endtask

    task automatic t_src_rotate();
        man_pu = 2'b11; man_pd = 2'b11;
        tog_ctrl = 3'b111;
        #1;
        chk("R3 blank", {4'd0, sw_pu, sw_pd}, 8'h00);
        tick(1);
        chk("R3 R4 first", {4'd0, sw_pu, sw_pd}, 8'h04);
        tick(7);
        chk("R4 end cc1", {4'd0, sw_pu, sw_pd}, 8'h04);
        tick(1);
        chk("R4 cc2", {4'd0, sw_pu, sw_pd}, 8'h08);
        man_pu = 2'b00; man_pd = 2'b10;
        tick(8);
        chk("R3 R4 back cc1", {4'd0, sw_pu, sw_pd}, 8'h04);
        stop_tog();
        chk("R2 after", {4'd0, sw_pu, sw_pd}, 8'h02);
    endtask

    task automatic t_sink_only();
        start_tog(2'd2);
        chk("R5 pd", {4'd0, sw_pu, sw_pd}, 8'h03);
        tick(20);
        chk("R5 held", {4'd0, sw_pu, sw_pd}, 8'h03);
        stop_tog();
    endtask

    task automatic t_dual();
        start_tog(2'd1);
        chk("R6 ph0", {4'd0, sw_pu, sw_pd}, 8'h04);
        tick(8);
        chk("R6 ph1", {4'd0, sw_pu, sw_pd}, 8'h08);
        tick(8);
        chk("R6 ph2", {4'd0, sw_pu, sw_pd}, 8'h03);
        tick(8);
        chk("R6 wrap", {4'd0, sw_pu, sw_pd}, 8'h04);
        stop_tog();
    endtask

    task automatic t_none();
        man_pu = 2'b11; man_pd = 2'b11;
        start_tog(2'd0);
        rd_seen = 2'b11; ra_seen = 2'b11; rp_seen = 2'b11;
        tick(30);
        chk("R7 sw", {4'd0, sw_pu, sw_pd}, 8'h00);
        chk("R7 code", {5'd0, settle_code}, 8'h00);
        chk("R7 irq", {7'd0, done_irq}, 8'h00);
        rd_seen = 0; ra_seen = 0; rp_seen = 0;
        stop_tog();
    endtask

    task automatic t_src1_settle();
        start_tog(2'd3);
        rd_seen = 2'b01;
        tick(1);
        chk("R9 one sample", {5'd0, settle_code}, 8'h00);
        tick(1);
        chk("R8 src1", {5'd0, settle_code}, 8'h01);
        chk("R11 pulse", {6'd0, done_pulse, done_irq}, 8'h03);
        tick(1);
        chk("R11 pulse end", {6'd0, done_pulse, done_irq}, 8'h01);
        tick(20);
        chk("R10 frozen", {1'b0, settle_code, sw_pu, sw_pd}, 8'h14);
        chk("R11 sticky", {7'd0, done_irq}, 8'h01);
        ack_irq();
        chk("R11 ack", {7'd0, done_irq}, 8'h00);
        rd_seen = 0;
        stop_tog();
        tick(3);
        chk("R13 kept", {5'd0, settle_code}, 8'h01);
        start_tog(2'd3);
        chk("R12 cleared", {5'd0, settle_code}, 8'h00);
        chk("R12 restart", {4'd0, sw_pu, sw_pd}, 8'h04);
        stop_tog();
    endtask

    task automatic t_glitch();
        start_tog(2'd3);
        rd_seen = 2'b01; tick(1);
        rd_seen = 2'b00; tick(1);
        tick(5);
        chk("R9 glitch code", {5'd0, settle_code}, 8'h00);
        chk("R9 glitch irq", {7'd0, done_irq}, 8'h00);
        stop_tog();
    endtask

    task automatic t_src2();
        start_tog(2'd3);
        rd_seen = 2'b10;
        tick(6);
        chk("R8 unpulled pin ignored", {5'd0, settle_code}, 8'h00);
        tick(3);
        chk("R9 first sample cc2", {5'd0, settle_code}, 8'h00);
        tick(1);
        chk("R8 src2", {1'b0, settle_code, sw_pu, sw_pd}, 8'h28);
        ack_irq();
        rd_seen = 0;
        stop_tog();
    endtask

    task automatic t_audio();
        start_tog(2'd3);
        ra_seen = 2'b11;
        tick(2);
        chk("R8 audio", {5'd0, settle_code}, 8'h07);
        ack_irq();
        ra_seen = 0;
        stop_tog();
    endtask

    task automatic t_dual_sink();
        start_tog(2'd1);
        rp_seen = 2'b11;
        tick(17);
        chk("R6 no sink early", {5'd0, settle_code}, 8'h00);
        tick(1);
        chk("R8 snk1 prio", {1'b0, settle_code, sw_pu, sw_pd}, 8'h53);
        ack_irq();
        rp_seen = 0;
        stop_tog();
    endtask

    task automatic t_sink_cc2();
        start_tog(2'd2);
        rd_seen = 2'b11;
        tick(5);
        chk("R8 rd in sink ignored", {5'd0, settle_code}, 8'h00);
        rd_seen = 0; rp_seen = 2'b10;
        tick(2);
        chk("R8 snk2", {5'd0, settle_code}, 8'h06);
        ack_irq();
        rp_seen = 0;
        stop_tog();
    endtask

    initial begin
        rst = 1'b1; tog_ctrl = 3'b000; man_pu = 0; man_pd = 0;
        rd_seen = 0; ra_seen = 0; rp_seen = 0; irq_ack = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_manual();
        t_src_rotate();
        t_sink_only();
        t_dual();
        t_none();
        t_src1_settle();
        t_glitch();
        t_src2();
        t_audio();
        t_dual_sink();
        t_sink_cc2();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule